// File: doc/BRIEF.md
# Synchronous Byte Shift Port

This block is a half-duplex serial port that moves one byte at a time over a data line plus a shift clock that the block drives itself. It runs from its own machine-cycle timing generator. A machine cycle is twelve clocks long: six states, each with two phases. The position within the cycle is numbered as slot = 2*(state-1) + (phase-1), so slot 0 is state 1 phase 1 and slot 11 is state 6 phase 2. Every event of the port is tied to a fixed slot. Each transfer moves one bit per machine cycle, least significant bit first.

A transmit starts when the host writes a byte while the port is idle. The byte is shifted out on `sd_o`, and `sclk_o` pulses low once per bit. A receive starts when receive is enabled and the receive flag is clear. The port then pulses `sclk_o` and shifts in the bits it samples on `sd_i`. Two flags report completion: `ti` for transmit and `ri` for receive. Each flag stays set until the host clears it. The length of a transfer is not counted. Instead a single marker bit moves through the shift register, and the transfer ends when that marker reaches the far end.

The outbound data line and the inbound data line are separate ports. Only one direction is ever active at a time.

Top module: `ssp_sync_port`

## Requirements
- R1: Reset state.
  - While reset is asserted, and until the first transfer, the outputs are `sclk_o`=1, `sd_o`=1, `ti`=`ri`=0, `send_act`=`recv_act`=0 and `rx_buf`=0.
  - `rst_n` is released synchronously inside the block. Slot 0 of machine cycle 0 is the clock period between the second and third rising edges after `rst_n` goes high.
  - The slot then advances by one every clock and wraps from 11 to 0.
- R2: Transmit start and bit order.
  - A one-clock `buf_wr` pulse in any slot of machine cycle w, with the port idle, is accepted.
  - `send_act` is low throughout cycle w+1 and is high from slot 0 of cycle w+2.
  - Bit k of the byte (bit 0 first) is on `sd_o` for the whole of cycle w+2+k, for k=0..7.
- R3: Shift clock.
  - While `send_act` or `recv_act` is high, `sclk_o` is low in slots 4..9 (states 3 to 5) and high in the other slots.
  - While neither is high, `sclk_o` stays high.
  - Each transfer gives 8 low pulses, one in each of its 8 bit cycles.
- R4: Transmit end.
  - `send_act` falls and `ti` rises on the same edge. Both changes are visible from slot 1 of cycle w+10; in slot 0 of that cycle `send_act` is still 1 and `ti` is still 0.
  - After the transfer, `sd_o` keeps bit 7 until the next transmit starts.
- R5: A `buf_wr` pulse has no effect, and its byte is never sent, when any of these holds:
  - a transmit is waiting to start;
  - a transmit is running;
  - a receive is waiting to start or running.
- R6: Receive start.
  - If, at the end of slot 11 of cycle c, `rx_en`=1, `ri`=0, no transmit is waiting or running, and no `buf_wr` is present, a receive starts.
  - `recv_act` is low in cycle c+1 and is high from slot 1 of cycle c+2.
- R7: Receive sampling and bit order.
  - `sd_i` is sampled at the end of slot 9 of cycles c+2..c+9.
  - The sample taken in cycle c+2+k becomes bit k of `rx_buf`.
  - The value of `sd_i` in any other slot has no effect.
- R8: Receive end.
  - `rx_buf` shows the new byte from slot 0 of cycle c+10.
  - `recv_act` falls and `ri` rises together, both visible from slot 1 of cycle c+10.
- R9: Flag hold and clear.
  - `ti` and `ri` stay set until a one-clock `ti_clr` or `ri_clr` pulse. The flag is 0 on the following clock.
  - A clear on the same edge that sets a flag loses: the flag ends up set.
  - While `ri`=1, no new receive starts, even with `rx_en`=1.
- R10: Half duplex.
  - `send_act` and `recv_act` are never both high.
  - A `buf_wr` on the same edge as a receive start condition wins, and the receive does not start.
  - With `rx_en` raised during a transmit written in cycle w, the receive start cycle c is w+10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one clock per phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_wr | input | 1 | One-clock strobe that writes a byte for transmit |
| buf_wdata | input | DATA_W | Byte presented with `buf_wr` |
| rx_en | input | 1 | Receive enable |
| ti_clr | input | 1 | One-clock pulse that clears `ti` |
| ri_clr | input | 1 | One-clock pulse that clears `ri` |
| sd_i | input | 1 | Serial data in from the pin |
| sd_o | output | 1 | Serial data out to the pin |
| sclk_o | output | 1 | Shift clock out to the pin |
| send_act | output | 1 | Transmit shifting in progress |
| recv_act | output | 1 | Receive shifting in progress |
| ti | output | 1 | Transmit complete flag |
| ri | output | 1 | Receive complete flag |
| rx_buf | output | DATA_W | Last received byte |

## Verification
The assertions assume that `buf_wr`, `ti_clr` and `ri_clr` are single-clock pulses and that every input is synchronous to `clk`. The stimulus respects this by driving all inputs on falling edges and dropping each strobe one clock later.

Writes and receive enables are placed in random and chosen slots of the machine cycle. This checks that the start timing does not depend on which slot the request lands in. `sd_i` is driven to the wrong value after the slot-9 sample in every bit cycle, so sampling in any other slot corrupts the received byte.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int STATES = 6;
  localparam int PHASES = 2;
  localparam int SLOTS  = STATES * PHASES;
  localparam int SLOT_W = $clog2(SLOTS);

  typedef logic [SLOT_W-1:0] slot_t;

  // slot index of a given state (1..STATES) and phase (1..PHASES)
  function automatic slot_t slot_of(input int st, input int ph);
    return slot_t'((st - 1) * PHASES + (ph - 1));
  endfunction

  localparam slot_t SL_END    = slot_of(1, 1);       // flags set, shifting ends
  localparam slot_t SL_LO_BEG = slot_of(3, 1);       // shift clock low from here
  localparam slot_t SL_LO_END = slot_of(5, 2);       // ... up to here
  localparam slot_t SL_SAMPLE = slot_of(5, 2);       // serial input sampled
  localparam slot_t SL_SHIFT  = slot_of(6, 2);       // shift registers move
  localparam slot_t SL_LAST   = slot_t'(SLOTS - 1);

  typedef enum logic [1:0] {TX_IDLE, TX_PEND, TX_ARM, TX_RUN} tx_stage_e;
  typedef enum logic [1:0] {RX_IDLE, RX_ARM, RX_LOAD, RX_RUN} rx_stage_e;
endpackage

// File: rtl/ssp_timing.sv
module ssp_timing
  import ssp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output slot_t slot_o
);
  slot_t slot_q, slot_d;

  always_comb begin
    slot_d = (slot_q == SL_LAST) ? '0 : slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assign slot_o = slot_q;

  a_r1_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= SL_LAST);
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_t             slot_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rx_busy_i,
  input  logic              ti_clr_i,
  output logic              busy_o,
  output logic              send_o,
  output logic              sd_o,
  output logic              ti_o
);
  localparam int SR_W = DATA_W + 1;

  tx_stage_e       stage_q, stage_d;
  logic [SR_W-1:0] shreg_q, shreg_d;
  logic            last_q, last_d;
  logic            sd_q, sd_d;
  logic            ti_q, ti_d;
  logic            ti_set;
  logic            at_shift, at_end, accept;

  always_comb begin
    at_shift = (slot_i == SL_SHIFT);
    at_end   = (slot_i == SL_END);
    accept   = wr_i && (stage_q == TX_IDLE) && !rx_busy_i;
    stage_d  = stage_q;
    shreg_d  = shreg_q;
    last_d   = last_q;
    sd_d     = sd_q;
    ti_set   = 1'b0;
    unique case (stage_q)
      TX_IDLE: if (accept) begin
        shreg_d = {1'b1, wdata_i};            // marker above the MSB
        stage_d = at_shift ? TX_ARM : TX_PEND;
      end
      TX_PEND: if (at_shift) stage_d = TX_ARM;
      TX_ARM: if (at_shift) begin
        stage_d = TX_RUN;
        sd_d    = shreg_q[0];
      end
      TX_RUN: begin
        if (at_shift && !last_q) begin
          shreg_d = {1'b0, shreg_q[SR_W-1:1]};
          if (shreg_q[SR_W-1:2] == '0) last_d = 1'b1;   // marker next to MSB
          else                         sd_d   = shreg_q[1];
        end
        if (at_end && last_q) begin
          stage_d = TX_IDLE;
          last_d  = 1'b0;
          ti_set  = 1'b1;
        end
      end
      default: stage_d = TX_IDLE;
    endcase
    ti_d = ti_set ? 1'b1 : (ti_clr_i ? 1'b0 : ti_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= TX_IDLE;
      shreg_q <= '0;
      last_q  <= 1'b0;
      sd_q    <= 1'b1;
      ti_q    <= 1'b0;
    end else begin
      stage_q <= stage_d;
      shreg_q <= shreg_d;
      last_q  <= last_d;
      sd_q    <= sd_d;
      ti_q    <= ti_d;
    end
  end

  assign busy_o = (stage_q != TX_IDLE);
  assign send_o = (stage_q == TX_RUN);
  assign sd_o   = sd_q;
  assign ti_o   = ti_q;

  // R4: the flag rises only as shifting ends
  a_r4_ti_at_send_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ti_q) |-> $fell(send_o));
  // R2: the output bit moves only on the shift slot
  a_r2_sd_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (send_o && slot_i != SL_END) |-> $stable(sd_q));
  // R5: a write while busy leaves the shift register alone
  a_r5_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && stage_q != TX_IDLE && (stage_q != TX_RUN || !at_shift)) |=> $stable(shreg_q));
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_t             slot_i,
  input  logic              rx_en_i,
  input  logic              tx_req_i,
  input  logic              sd_i,
  input  logic              ri_clr_i,
  output logic              busy_o,
  output logic              recv_o,
  output logic [DATA_W-1:0] buf_o,
  output logic              ri_o
);
  rx_stage_e         stage_q, stage_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic              smp_q, smp_d;
  logic              last_q, last_d;
  logic              ri_q, ri_d;
  logic              ri_set;
  logic              at_shift, at_end;

  always_comb begin
    at_shift = (slot_i == SL_SHIFT);
    at_end   = (slot_i == SL_END);
    stage_d  = stage_q;
    shreg_d  = shreg_q;
    buf_d    = buf_q;
    smp_d    = smp_q;
    last_d   = last_q;
    ri_set   = 1'b0;
    unique case (stage_q)
      RX_IDLE: if (at_shift && rx_en_i && !ri_q && !tx_req_i) stage_d = RX_ARM;
      RX_ARM: if (at_shift) begin
        shreg_d = {1'b0, {(DATA_W-1){1'b1}}};  // zero marker at the entry end
        stage_d = RX_LOAD;
      end
      RX_LOAD: if (at_end) stage_d = RX_RUN;
      RX_RUN: begin
        if (slot_i == SL_SAMPLE) smp_d = sd_i;
        if (at_shift && !last_q) begin
          shreg_d = {smp_q, shreg_q[DATA_W-1:1]};
          if (!shreg_q[0]) begin                  // marker reached the far end
            last_d = 1'b1;
            buf_d  = {smp_q, shreg_q[DATA_W-1:1]};
          end
        end
        if (at_end && last_q) begin
          stage_d = RX_IDLE;
          last_d  = 1'b0;
          ri_set  = 1'b1;
        end
      end
      default: stage_d = RX_IDLE;
    endcase
    ri_d = ri_set ? 1'b1 : (ri_clr_i ? 1'b0 : ri_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= RX_IDLE;
      shreg_q <= '0;
      buf_q   <= '0;
      smp_q   <= 1'b0;
      last_q  <= 1'b0;
      ri_q    <= 1'b0;
    end else begin
      stage_q <= stage_d;
      shreg_q <= shreg_d;
      buf_q   <= buf_d;
      smp_q   <= smp_d;
      last_q  <= last_d;
      ri_q    <= ri_d;
    end
  end

  assign busy_o = (stage_q != RX_IDLE);
  assign recv_o = (stage_q == RX_RUN);
  assign buf_o  = buf_q;
  assign ri_o   = ri_q;

  // R8: the flag rises only as receiving ends
  a_r8_ri_at_recv_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ri_q) |-> $fell(recv_o));
  // R9: a pending flag blocks a new receive
  a_r9_ri_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == RX_IDLE && ri_q) |=> (stage_q == RX_IDLE));
  // R10: transmit activity holds the receiver idle
  a_r10_tx_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == RX_IDLE && tx_req_i) |=> (stage_q == RX_IDLE));
endmodule

// File: rtl/ssp_sync_port.sv
module ssp_sync_port
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] buf_wdata,
  input  logic              rx_en,
  input  logic              ti_clr,
  input  logic              ri_clr,
  input  logic              sd_i,
  output logic              sd_o,
  output logic              sclk_o,
  output logic              send_act,
  output logic              recv_act,
  output logic              ti,
  output logic              ri,
  output logic [DATA_W-1:0] rx_buf
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  slot_t      slot;
  logic       tx_busy, rx_busy;
  logic       in_low_slots;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ssp_timing u_timing (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .slot_o (slot)
  );

  ssp_tx #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .slot_i    (slot),
    .wr_i      (buf_wr),
    .wdata_i   (buf_wdata),
    .rx_busy_i (rx_busy),
    .ti_clr_i  (ti_clr),
    .busy_o    (tx_busy),
    .send_o    (send_act),
    .sd_o      (sd_o),
    .ti_o      (ti)
  );

  ssp_rx #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .slot_i   (slot),
    .rx_en_i  (rx_en),
    .tx_req_i (tx_busy || buf_wr),
    .sd_i     (sd_i),
    .ri_clr_i (ri_clr),
    .busy_o   (rx_busy),
    .recv_o   (recv_act),
    .buf_o    (rx_buf),
    .ri_o     (ri)
  );

  assign in_low_slots = (slot >= SL_LO_BEG) && (slot <= SL_LO_END);
  assign sclk_o       = !((send_act || recv_act) && in_low_slots);

  // R10: one direction at a time
  a_r10_half_duplex: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(send_act && recv_act));
  // R3: the clock line idles high
  a_r3_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_int_n)
    !sclk_o |-> (send_act || recv_act));
endmodule

// File: tb/ssp_sync_port_tb_top.sv
module ssp_sync_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       buf_wr, rx_en, ti_clr, ri_clr, sd_i;
  logic [7:0] buf_wdata;
  logic       sd_o, sclk_o, send_act, recv_act, ti, ri;
  logic [7:0] rx_buf;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int slot = 0;
  logic run = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  ssp_sync_port dut_i (
    .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .rx_en(rx_en), .ti_clr(ti_clr), .ri_clr(ri_clr), .sd_i(sd_i),
    .sd_o(sd_o), .sclk_o(sclk_o), .send_act(send_act), .recv_act(recv_act),
    .ti(ti), .ri(ri), .rx_buf(rx_buf)
  );

  // bench view of the machine cycle, from the R1 alignment rule
  always @(posedge clk) begin
    if (run) begin
      if (slot == 11) begin
        slot <= 0;
        cyc  <= cyc + 1;
      end else begin
        slot <= slot + 1;
      end
    end
  end

  task automatic check(input int act, input int exp, input string tag);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d slot %0d)", tag, act, exp, cyc, slot);
    end
  endtask

  task automatic wait_at(input int c, input int s);
    do @(negedge clk); while (!(cyc == c && slot == s));
  endtask

  task automatic tx_xfer(input logic [7:0] data, input int wslot, input bit do_wr, input bit clr_race);
    int w;
    w = cyc + 1;
    wait_at(w, wslot);
    buf_wr = 1'b1; buf_wdata = data;
    @(negedge clk); buf_wr = 1'b0;
    wait_at(w + 1, 6);
    check(send_act, 0, "R2 gap cycle before send");
    check(sclk_o, 1, "R3 clock high before send");
    for (int k = 0; k < 8; k++) begin
      wait_at(w + 2 + k, 1);
      check(send_act, 1, "R2 send active");
      check(sclk_o, 1, "R3 clock high in state 1");
      wait_at(w + 2 + k, 6);
      check(sclk_o, 0, "R3 clock low in state 4");
      check(sd_o, data[k], "R2 transmit bit");
      if (k == 3 && do_wr) begin
        buf_wr = 1'b1; buf_wdata = ~data;
        @(negedge clk); buf_wr = 1'b0;
      end
    end
    wait_at(w + 10, 0);
    check(ti, 0, "R4 ti not before end");
    check(send_act, 1, "R4 send still high in slot 0");
    if (clr_race) ti_clr = 1'b1;
    @(negedge clk); ti_clr = 1'b0;
    check(ti, 1, clr_race ? "R9 set beats clear" : "R4 ti set");
    check(send_act, 0, "R4 send cleared");
    wait_at(w + 11, 6);
    check(sclk_o, 1, "R3 clock idles high");
    check(sd_o, data[7], "R4 data holds last bit");
    check(ti, 1, "R9 ti holds");
    check(send_act, 0, do_wr ? "R5 write during transmit ignored" : "R4 stays idle");
    ti_clr = 1'b1;
    @(negedge clk); ti_clr = 1'b0;
    check(ti, 0, "R9 ti cleared");
  endtask

  task automatic rx_run(input int c, input logic [7:0] data, input bit do_wr);
    fork
      begin
        for (int k = 0; k < 8; k++) begin
          wait_at(c + 2 + k, 0);
          sd_i = data[k];
          wait_at(c + 2 + k, 10);
          sd_i = ~data[k];    // wrong value outside the sampling slot (R7)
        end
      end
      begin
        wait_at(c + 1, 6);
        check(recv_act, 0, "R6 not active in start+1");
        check(sclk_o, 1, "R3 clock high before receive");
        wait_at(c + 2, 1);
        check(recv_act, 1, "R6 receive active");
        for (int k = 0; k < 8; k++) begin
          wait_at(c + 2 + k, 6);
          check(sclk_o, 0, "R3 receive clock low");
          if (k == 3 && do_wr) begin
            buf_wr = 1'b1; buf_wdata = 8'h3C;
            @(negedge clk); buf_wr = 1'b0;
          end
          if (k == 7 && do_wr) check(send_act, 0, "R5 write during receive ignored");
        end
        wait_at(c + 10, 0);
        check(ri, 0, "R8 ri not before end");
        check(recv_act, 1, "R8 receive high in slot 0");
        check(rx_buf, data, "R7 received byte");
        wait_at(c + 10, 1);
        check(ri, 1, "R8 ri set");
        check(recv_act, 0, "R8 receive cleared");
      end
    join
  endtask

  task automatic rx_xfer(input logic [7:0] data, input int enslot, input bit do_wr);
    int c;
    c = cyc + 1;
    wait_at(c, enslot);
    rx_en = 1'b1;
    rx_run(c, data, do_wr);
    wait_at(c + 13, 6);
    check(recv_act, 0, "R9 ri blocks new receive");
    check(sclk_o, 1, "R9 no clock while blocked");
    check(ri, 1, "R9 ri holds");
    rx_en = 1'b0; ri_clr = 1'b1;
    @(negedge clk); ri_clr = 1'b0;
    check(ri, 0, "R9 ri cleared");
  endtask

  task automatic half_duplex();
    int w;
    w = cyc + 1;
    wait_at(w, 11);
    buf_wr = 1'b1; buf_wdata = 8'hC3;
    @(negedge clk); buf_wr = 1'b0;
    wait_at(w + 4, 3);
    rx_en = 1'b1;
    wait_at(w + 9, 6);
    check(recv_act, 0, "R10 receive waits for transmit");
    check(send_act, 1, "R10 transmit running");
    rx_run(w + 10, 8'h96, 1'b0);
    rx_en = 1'b0; ri_clr = 1'b1; ti_clr = 1'b1;
    @(negedge clk); ri_clr = 1'b0; ti_clr = 1'b0;
    check(ri, 0, "R10 cleanup ri");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0C51));
    rst_n = 1'b0; buf_wr = 1'b0; buf_wdata = '0; rx_en = 1'b0;
    ti_clr = 1'b0; ri_clr = 1'b0; sd_i = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(sclk_o, 1, "R1 reset sclk");
    check(sd_o, 1, "R1 reset sd_o");
    check(ti, 0, "R1 reset ti");
    check(ri, 0, "R1 reset ri");
    check(send_act, 0, "R1 reset send");
    check(recv_act, 0, "R1 reset recv");
    check(rx_buf, 0, "R1 reset rx_buf");
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    run = 1'b1;   // slot 0 of cycle 0 is the current period

    tx_xfer(8'hA5, 11, 1'b0, 1'b0);
    tx_xfer(8'h01, 0, 1'b1, 1'b0);
    tx_xfer(8'h80, 5, 1'b0, 1'b1);
    rx_xfer(8'h5A, 11, 1'b0);
    rx_xfer(8'hFF, 0, 1'b1);
    rx_xfer(8'h00, 7, 1'b0);
    half_duplex();
    for (int i = 0; i < 10; i++) begin
      logic [7:0] b;
      int s;
      b = 8'($urandom_range(0, 255));
      s = $urandom_range(0, 11);
      if ($urandom_range(0, 1) == 1) tx_xfer(b, s, 1'b0, 1'b0);
      else                           rx_xfer(b, s, 1'b0);
    end
    repeat (24) @(negedge clk);
    finish_run();
  end
endmodule